// File: doc/BRIEF.md
# Auxiliary Channel Transaction Retry Controller

This block sits between a client that wants one auxiliary-channel transaction completed and a single-shot engine that performs one attempt at a time. The client raises `req` with the direction and the requested length. The controller launches the engine, classifies each attempt by its outcome class and reply code, and either finishes or launches again. It keeps one budget per kind of failure, and some kinds clear the budget of another kind. It inserts a fixed wait only where a retry calls for one.

Each attempt ends with a one-cycle `xfer_done` from the engine. At that point the block reads the outcome, the reply code and the returned byte count. A retry starts either at once or after a wait measured in microseconds. The wait is turned into clock cycles through the `CYC_PER_US` parameter. The result appears as a one-cycle `done` pulse, and `ok` holds the verdict until the next request is accepted.

Outcome codes on `xfer_outcome`: 0 = succeeded, 1 = timeout, 2 = invalid reply, 3 = disconnect, 4..7 = unknown. Reply codes on `xfer_reply`, used only when the outcome is 0: 0 = ACK, 1 = native NACK, 2 = native DEFER, 3 = I2C-over-AUX NACK, 4 = I2C-over-AUX DEFER, 5 = I2C DEFER, 6 = hot-plug disconnect, 7..15 = unrecognised.

Top module: `aux_retry_ctrl`

## Requirements
- R1: While reset is applied and just after it is released, `done`, `ok`, `xfer_start` and `waiting` are all 0.
- R2: A `req` seen while idle is accepted. `xfer_start` goes high for exactly one cycle in the next cycle. Every failure budget and the attempt count start from zero for that request.
- R3: Outcome 0 with reply 0 ends the request with `ok`=1 when the request is a write, or when `xfer_bytes` equals the requested length. No further `xfer_start` follows.
- R4: Outcome 0 with reply 0 on a read whose `xfer_bytes` differs from the requested length is a short read. The block holds `waiting` high for 300*`CYC_PER_US` cycles and then retries. The 7th short read fails the request.
- R5: Replies 2, 3 and 4 share one defer budget. Each is retried at once with no wait. The 7th of them fails the request.
- R6: Reply 5 clears the shared defer budget and counts against its own budget. It is retried at once, and the 7th occurrence fails the request.
- R7: Replies 1 and 6, and any reply from 7 to 15, fail the request at once with `ok`=0.
- R8: Outcome 2 fails the request on its 2nd occurrence. Otherwise the block holds `waiting` high for 400*`CYC_PER_US` cycles before it retries.
- R9: Outcome 1 fails the request on its 3rd occurrence. Otherwise the block retries at once with no wait.
- R10: Outcome 0 clears both the timeout budget and the invalid-reply budget, whatever the reply code.
- R11: Outcome 3 and outcomes 4..7 fail the request at once with `ok`=0.
- R12: At most 7 attempts are launched per request. If the 7th attempt would need a retry, the request fails instead, with no wait.
- R13: `done` lasts one cycle, and `xfer_start` is never high while `waiting` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Client request, accepted when idle |
| req_write | input | 1 | 1 = write transaction, 0 = read |
| req_len | input | LEN_W | Requested payload length in bytes |
| xfer_start | output | 1 | One-cycle launch of an engine attempt |
| xfer_done | input | 1 | One-cycle end of the outstanding attempt |
| xfer_outcome | input | 3 | Outcome class of the attempt |
| xfer_reply | input | 4 | Reply code of the attempt |
| xfer_bytes | input | LEN_W | Payload bytes returned by the attempt |
| waiting | output | 1 | High while a retry wait interval runs |
| done | output | 1 | One-cycle end of the request |
| ok | output | 1 | Verdict of the last request, 1 = success |

## Verification
The assertions assume that `xfer_done` pulses only while an attempt is outstanding, meaning after a `xfer_start` and before the matching completion. They also assume the outcome, reply and byte count are valid in that same cycle. The bench engine model keeps to this. It answers every `xfer_start` with exactly one `xfer_done`, two cycles later, and never pulses `xfer_done` otherwise. Each request gets a seven-entry response script, drawn at random or written for a corner case. The script is consumed in order, one entry per attempt, and `req` is raised only while the block is idle.

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl #(
  parameter int LEN_W         = 5,
  parameter int CYC_PER_US    = 100,
  parameter int MAX_TRIES     = 7,
  parameter int ACK_LIM       = 7,
  parameter int DEF_LIM       = 7,
  parameter int I2C_DEF_LIM   = 7,
  parameter int INV_LIM       = 2,
  parameter int TO_LIM        = 3,
  parameter int SHORT_WAIT_US = 300,
  parameter int INV_WAIT_US   = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_write,
  input  logic [LEN_W-1:0] req_len,
  output logic             xfer_start,
  input  logic             xfer_done,
  input  logic [2:0]       xfer_outcome,
  input  logic [3:0]       xfer_reply,
  input  logic [LEN_W-1:0] xfer_bytes,
  output logic             waiting,
  output logic             done,
  output logic             ok
);
  localparam int CNT_W     = $clog2(MAX_TRIES + 1);
  localparam int SHORT_CYC = SHORT_WAIT_US * CYC_PER_US;
  localparam int LONG_CYC  = INV_WAIT_US * CYC_PER_US;
  localparam int TMR_W     = $clog2(LONG_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_BUSY, S_WAIT} st_t;
  typedef enum logic [1:0] {A_FAIL, A_OK, A_AGAIN, A_WAIT} act_t;

  st_t              st;
  act_t             act;
  logic             long_wait, busy, accept;
  logic             wr_l;
  logic [LEN_W-1:0] len_l;
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] tries, to_c, inv_c, ack_c, def_c, i2_c;
  logic [CNT_W-1:0] n_to, n_inv, n_ack, n_def, n_i2;

  assign busy       = (st == S_BUSY);
  assign accept     = req && (st == S_IDLE);
  assign xfer_start = (st == S_LAUNCH);
  assign waiting    = (st == S_WAIT);

  always_comb begin
    act = A_FAIL; long_wait = 1'b0;
    n_to = to_c; n_inv = inv_c; n_ack = ack_c; n_def = def_c; n_i2 = i2_c;
    case (xfer_outcome)
      3'd0: begin
        n_to = '0; n_inv = '0;
        case (xfer_reply)
          4'd0: begin
            if (wr_l || xfer_bytes == len_l) act = A_OK;
            else begin
              n_ack = ack_c + CNT_W'(1);
              act = (n_ack >= CNT_W'(ACK_LIM)) ? A_FAIL : A_WAIT;
            end
          end
          4'd2, 4'd3, 4'd4: begin
            n_def = def_c + CNT_W'(1);
            act = (n_def >= CNT_W'(DEF_LIM)) ? A_FAIL : A_AGAIN;
          end
          4'd5: begin
            n_def = '0;
            n_i2 = i2_c + CNT_W'(1);
            act = (n_i2 >= CNT_W'(I2C_DEF_LIM)) ? A_FAIL : A_AGAIN;
          end
          default: act = A_FAIL;
        endcase
      end
      3'd1: begin
        n_to = to_c + CNT_W'(1);
        act = (n_to >= CNT_W'(TO_LIM)) ? A_FAIL : A_AGAIN;
      end
      3'd2: begin
        n_inv = inv_c + CNT_W'(1);
        long_wait = 1'b1;
        act = (n_inv >= CNT_W'(INV_LIM)) ? A_FAIL : A_WAIT;
      end
      default: act = A_FAIL;
    endcase
    if ((act == A_AGAIN || act == A_WAIT) && tries >= CNT_W'(MAX_TRIES)) act = A_FAIL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; ok <= 1'b0; wr_l <= 1'b0; len_l <= '0; tmr <= '0;
      tries <= '0; to_c <= '0; inv_c <= '0; ack_c <= '0; def_c <= '0; i2_c <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          st <= S_LAUNCH; ok <= 1'b0; wr_l <= req_write; len_l <= req_len;
          tries <= '0; to_c <= '0; inv_c <= '0; ack_c <= '0; def_c <= '0; i2_c <= '0;
        end
        S_LAUNCH: begin
          st <= S_BUSY;
          tries <= tries + CNT_W'(1);
        end
        S_BUSY: if (xfer_done) begin
          to_c <= n_to; inv_c <= n_inv; ack_c <= n_ack; def_c <= n_def; i2_c <= n_i2;
          case (act)
            A_OK:    begin st <= S_IDLE; done <= 1'b1; ok <= 1'b1; end
            A_AGAIN: st <= S_LAUNCH;
            A_WAIT:  begin
              st <= S_WAIT;
              tmr <= long_wait ? TMR_W'(LONG_CYC - 1) : TMR_W'(SHORT_CYC - 1);
            end
            default: begin st <= S_IDLE; done <= 1'b1; ok <= 1'b0; end
          endcase
        end
        S_WAIT: begin
          if (tmr == '0) st <= S_LAUNCH;
          else tmr <= tmr - TMR_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_retry_ctrl_chk.sv
module aux_retry_ctrl_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_start,
  input logic             xfer_done,
  input logic [2:0]       xfer_outcome,
  input logic [3:0]       xfer_reply,
  input logic [LEN_W-1:0] xfer_bytes,
  input logic             waiting,
  input logic             done,
  input logic             ok,
  input logic             busy,
  input logic             wr_l,
  input logic [LEN_W-1:0] len_l
);
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_no_start_in_wait_R13: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !xfer_start);

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ack_success_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && xfer_outcome == 3'd0 && xfer_reply == 4'd0 &&
     (wr_l || xfer_bytes == len_l)) |=> (done && ok));

  assert_nack_fails_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && xfer_outcome == 3'd0 && xfer_reply == 4'd1) |=> (done && !ok));

  assert_disconnect_fails_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && xfer_outcome == 3'd3) |=> (done && !ok));

  assert_timeout_no_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && xfer_outcome == 3'd1) |=> !waiting);

  assert_wait_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waiting) |-> ($past(xfer_outcome) == 3'd2 ||
                        ($past(xfer_outcome) == 3'd0 && $past(xfer_reply) == 4'd0)));
endmodule

bind aux_retry_ctrl aux_retry_ctrl_chk #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_done(xfer_done),
  .xfer_outcome(xfer_outcome), .xfer_reply(xfer_reply), .xfer_bytes(xfer_bytes),
  .waiting(waiting), .done(done), .ok(ok), .busy(busy), .wr_l(wr_l), .len_l(len_l)
);

// File: tb/aux_retry_ctrl_test.sv
module aux_retry_ctrl_test;
  localparam int LEN_W = 5;
  localparam int CPU   = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic xfer_start, waiting, done, ok;
  logic xfer_done = 1'b0;
  logic [2:0] xfer_outcome = '0;
  logic [3:0] xfer_reply = '0;
  logic [LEN_W-1:0] xfer_bytes = '0;

  int checks = 0, errors = 0;
  int sc_o[7], sc_r[7], sc_b[7];
  int m_ok, m_att, m_wait;

  always #4 clk = ~clk;

  aux_retry_ctrl #(.LEN_W(LEN_W), .CYC_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write), .req_len(req_len),
    .xfer_start(xfer_start), .xfer_done(xfer_done), .xfer_outcome(xfer_outcome),
    .xfer_reply(xfer_reply), .xfer_bytes(xfer_bytes), .waiting(waiting),
    .done(done), .ok(ok));

  task automatic chk(input bit cond, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void model(input bit wr, input int len);
    int to = 0, inv = 0, ack = 0, def = 0, i2 = 0, res = -1, w;
    m_att = 0; m_wait = 0;
    for (int i = 0; i < 7; i++) begin
      w = 0;
      m_att++;
      case (sc_o[i])
        0: begin
          to = 0; inv = 0;
          case (sc_r[i])
            0: if (wr || sc_b[i] == len) res = 1;
               else begin ack++; if (ack >= 7) res = 0; else w = 300 * CPU; end
            2, 3, 4: begin def++; if (def >= 7) res = 0; end
            5: begin def = 0; i2++; if (i2 >= 7) res = 0; end
            default: res = 0;
          endcase
        end
        1: begin to++; if (to >= 3) res = 0; end
        2: begin inv++; if (inv >= 2) res = 0; else w = 400 * CPU; end
        default: res = 0;
      endcase
      if (res != -1) break;
      if (i < 6) m_wait += w;
    end
    m_ok = (res == 1) ? 1 : 0;
  endfunction

  task automatic fill(input int o, input int r, input int b);
    for (int i = 0; i < 7; i++) begin sc_o[i] = o; sc_r[i] = r; sc_b[i] = b; end
  endtask

  task automatic put(input int i, input int o, input int r, input int b);
    sc_o[i] = o; sc_r[i] = r; sc_b[i] = b;
  endtask

  task automatic run_txn(input bit wr, input int len, input string tag);
    int starts = 0, waits = 0, idx = 0, pend = -1, got_ok = -1;
    bit got = 0;
    model(wr, len);
    @(negedge clk);
    req = 1'b1; req_write = wr; req_len = LEN_W'(len);
    @(negedge clk);
    req = 1'b0;
    for (int c = 0; c < 6000 && !got; c++) begin
      if (c > 0) @(negedge clk);
      xfer_done = 1'b0;
      if (xfer_start) begin
        starts++; pend = 2;
        chk(!waiting, "R13", "start while waiting", 1, 0);
      end else if (pend > 0) pend--;
      if (pend == 0) begin
        if (idx < 7) begin
          xfer_done = 1'b1;
          xfer_outcome = 3'(sc_o[idx]); xfer_reply = 4'(sc_r[idx]); xfer_bytes = LEN_W'(sc_b[idx]);
        end
        idx++; pend = -1;
      end
      if (waiting) waits++;
      if (done) begin got = 1; got_ok = int'(ok); end
    end
    xfer_done = 1'b0;
    chk(got, tag, "done seen", int'(got), 1);
    chk(got_ok == m_ok, tag, "ok", got_ok, m_ok);
    chk(starts == m_att, tag, "attempts (R12)", starts, m_att);
    chk(waits == m_wait, tag, "wait cycles", waits, m_wait);
    @(negedge clk);
    chk(!done, "R13", "done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int len, r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!done && !ok && !xfer_start && !waiting, "R1", "outputs in reset", int'({done, ok, xfer_start, waiting}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !ok && !xfer_start && !waiting, "R1", "outputs after reset", int'({done, ok, xfer_start, waiting}), 0);

    fill(0, 0, 3); run_txn(1'b1, 8, "R3 write ack");
    fill(0, 0, 8); run_txn(1'b0, 8, "R3 read full ack");
    fill(0, 0, 7); run_txn(1'b0, 8, "R4 short read x7");
    fill(0, 0, 2); put(2, 0, 0, 5); run_txn(1'b0, 5, "R4 short then full");
    fill(0, 2, 0); put(6, 0, 0, 4); run_txn(1'b0, 4, "R5 defer x6 then ack");
    fill(0, 3, 0); put(1, 0, 4, 0); put(2, 0, 2, 0); run_txn(1'b1, 2, "R5 mixed defer x7");
    fill(0, 2, 0); put(5, 0, 5, 0); put(6, 0, 0, 1); run_txn(1'b1, 1, "R6 i2c defer clears defer");
    fill(0, 2, 0); put(3, 0, 5, 0); run_txn(1'b1, 1, "R6 defer after clear");
    fill(0, 5, 0); run_txn(1'b1, 1, "R6 i2c defer x7");
    fill(0, 1, 0); run_txn(1'b1, 1, "R7 nack");
    fill(0, 6, 0); run_txn(1'b1, 1, "R7 hpd reply");
    fill(0, 11, 0); run_txn(1'b1, 1, "R7 unknown reply");
    fill(2, 0, 0); run_txn(1'b1, 1, "R8 invalid x2");
    fill(2, 0, 0); put(1, 0, 0, 3); run_txn(1'b1, 3, "R8 invalid then ack");
    fill(1, 0, 0); run_txn(1'b1, 1, "R9 timeout x3");
    fill(1, 0, 0); put(2, 0, 0, 2); run_txn(1'b0, 2, "R9 timeout x2 then ack");
    fill(1, 0, 0); put(2, 0, 2, 0); put(5, 0, 0, 1); run_txn(1'b1, 1, "R10 success clears timeouts");
    fill(2, 0, 0); put(1, 0, 3, 0); put(3, 0, 0, 1); run_txn(1'b1, 1, "R10 success clears invalid");
    fill(3, 0, 0); run_txn(1'b1, 1, "R11 disconnect outcome");
    fill(6, 0, 0); run_txn(1'b1, 1, "R11 unknown outcome");
    fill(1, 0, 0); put(2, 0, 0, 1); run_txn(1'b1, 1, "R2 budgets A");
    fill(1, 0, 0); put(2, 0, 0, 1); run_txn(1'b1, 1, "R2 budgets cleared");
    fill(0, 2, 0); put(1, 1, 0, 0); put(3, 1, 0, 0); put(6, 0, 0, 1); run_txn(1'b1, 1, "R12 cap with mixed retries");

    for (int t = 0; t < 40; t++) begin
      len = 1 + int'($urandom % 16);
      for (int i = 0; i < 7; i++) begin
        r = int'($urandom % 10);
        sc_o[i] = (r < 6) ? 0 : (r < 8) ? 1 : (r < 9) ? 2 : (($urandom % 8 == 0) ? 3 + int'($urandom % 5) : 0);
        r = int'($urandom % 16);
        sc_r[i] = (r < 5) ? 0 : (r < 10) ? 2 + int'($urandom % 3) : (r < 13) ? 5 : (r == 13) ? 1 : (r == 14) ? 6 : 7 + int'($urandom % 9);
        sc_b[i] = ($urandom % 3 == 0) ? len - 1 : len;
      end
      run_txn(1'($urandom % 2), len, "R3 R4 R5 R6 R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule